// File: doc/BRIEF.md
# Smart Card Character I/O Engine

This block carries characters between a host-side byte stream and the single open-drain I/O line of a smart card. In asynchronous mode it frames each byte as a start bit, eight data bits and an even parity bit. It waits a programmable number of extra ETUs before each transmitted frame. On receive it samples each bit in the middle of its ETU and hands the decoded byte back. Two coding conventions are supported. Direct convention sends the least significant bit first, with a high level meaning 1. Inverse convention sends the most significant bit first, with all levels inverted, including the parity bit. The convention can come from a software bit. It can also be decided in hardware from the first character the card sends after a session starts.

Timing comes from an external `half_tick` strobe, which pulses twice per ETU. Every transmitted bit lasts two strobes. The receiver takes its first strobe after a falling edge as the middle of the start bit. When `sync_mode` is set, the character path is bypassed. Bit 0 of the last byte accepted on the transmit stream sets the line level. Bit 0 of `rx_data` follows the line one clock later. A control pin drives the card clock, except in builds for a clock-less slot (`HAS_CLK` = 0).

Back-pressure rules: a transmit byte is taken on a cycle with `tx_valid` and `tx_ready` both high. `tx_data` must stay stable while `tx_valid` waits. In asynchronous mode `tx_ready` stays low through the guard time, the frame and one stop ETU. In synchronous mode `tx_ready` is always high. A card cannot be stalled, so `rx_valid` stays high until a cycle with `rx_ready` high. A character that arrives before then replaces the unread one.

Top module: `sc_char_engine`

## Requirements
- R1: After reset the line is released (`io_drive_low` 0), `tx_ready` is 1, `rx_valid` is 0, `conv_state` is 0 (direct), `conv_err` is 0 and `card_clk` is 0.
- R2: With `conv_state` 0 a transmitted frame is a low start bit, then data bits LSB first with high meaning 1, then even parity (high when the byte has an odd count of ones), then a high stop ETU. Each bit lasts two half ticks. `tx_ready` is low until the stop ETU ends.
- R3: With `conv_state` 1 data bits go out MSB first with inverted levels, and the parity bit is also inverted.
- R4: The start bit begins exactly 2×`guard_etu` half ticks after the byte is accepted, so a guard of 0 starts it at once.
- R5: A received frame is sampled on the first half tick after the falling edge and on every second half tick after that. The decoded byte appears with `rx_valid` high and stays until `rx_ready`. `rx_parity_err` is 1 when the parity check fails.
- R6: With `conv_state` 1 received bits are inverted and reassembled MSB first.
- R7: With `auto_conv_n` 0, the first character completed while `start_session` is high sets `conv_state`. Raw line byte 3Bh (LSB first, high = 1) selects direct (0). Raw 03h, which is the inverse form of 3Fh, selects inverse (1). That character is decoded with the new convention, and later characters in the session leave `conv_state` unchanged.
- R8: In auto mode, any other first character leaves `conv_state` unchanged and sets `conv_err`. Lowering `start_session` clears `conv_err` and re-arms detection.
- R9: With `auto_conv_n` 1, `conv_state` follows `conv_sw`, and received characters do not change it.
- R10: In synchronous mode, `tx_ready` is 1 and `rx_valid` is 0. The clock after a transmit handshake, `io_drive_low` equals the inverse of bit 0 of the accepted byte. `rx_data` is 0 in bits 7:1, and bit 0 is the line level one clock earlier.
- R11: `card_clk` equals `sync_clk_ctl` in synchronous mode and is 0 in asynchronous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_tick | input | 1 | Strobe, two per ETU |
| sync_mode | input | 1 | 0 asynchronous, 1 synchronous bypass |
| auto_conv_n | input | 1 | 0 enables convention detection |
| conv_sw | input | 1 | Software convention, 1 = inverse |
| start_session | input | 1 | High during answer-to-reset session |
| guard_etu | input | GUARD_W | Extra ETUs before each transmit frame |
| sync_clk_ctl | input | 1 | Card clock level in synchronous mode |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Transmit byte can be taken |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte valid |
| rx_ready | input | 1 | Received byte consumed |
| rx_data | output | 8 | Received byte |
| rx_parity_err | output | 1 | Parity check failed for rx_data |
| conv_state | output | 1 | Convention in use, 1 = inverse |
| conv_err | output | 1 | First character was not a known pattern |
| io_in | input | 1 | Card I/O line level |
| io_drive_low | output | 1 | Pull the card I/O line low |
| card_clk | output | 1 | Card clock in synchronous mode |

## Verification
The transmitter is tried with bytes of different bit patterns under both conventions and with guard counts of zero and nonzero. Bit-order mistakes, missed inversions and off-by-one guard waits each show up at a different mid-bit sample. The receiver gets direct and inverse frames, and a frame with a deliberately wrong parity bit, which separates decoding faults from parity faults. Detection is driven with the two valid initial patterns, with a later character in the same session and with an unknown pattern. This shows that only the first character decides, and that an unknown pattern leaves the convention alone. Synchronous mode is driven with bytes whose bit 0 differs and with both card line levels.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int SC_DATA_W = 8;
  localparam logic [SC_DATA_W-1:0] TS_DIRECT_RAW  = 8'h3B;
  localparam logic [SC_DATA_W-1:0] TS_INVERSE_RAW = 8'h03;

  typedef enum logic [1:0] {RX_IDLE, RX_RUN, RX_STOP} rx_st_e;

  // line levels for a byte: {parity level, data levels in send order}
  function automatic logic [SC_DATA_W:0] sc_encode(input logic [SC_DATA_W-1:0] d,
                                                   input logic inv);
    logic [SC_DATA_W-1:0] r;
    for (int i = 0; i < SC_DATA_W; i++)
      r[i] = inv ? ~d[SC_DATA_W-1-i] : d[i];
    return {inv ? ~(^d) : (^d), r};
  endfunction

  // decode line levels: {parity error, data}
  function automatic logic [SC_DATA_W:0] sc_decode(input logic [SC_DATA_W-1:0] r,
                                                   input logic pl, input logic inv);
    logic [SC_DATA_W-1:0] d;
    logic p;
    for (int i = 0; i < SC_DATA_W; i++)
      d[i] = inv ? ~r[SC_DATA_W-1-i] : r[i];
    p = inv ? ~pl : pl;
    return {(^d) ^ p, d};
  endfunction
endpackage

// File: rtl/sc_tx.sv
module sc_tx
  import sc_pkg::*;
#(
  parameter int GUARD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 half_tick,
  input  logic                 inv,
  input  logic [GUARD_W-1:0]   guard,
  input  logic                 in_valid,
  input  logic [SC_DATA_W-1:0] in_data,
  output logic                 in_ready,
  output logic                 busy,
  output logic                 drive_low
);
  localparam int SH_W     = SC_DATA_W + 3;          // start, data, parity, stop
  localparam int LAST_POS = 2 * SH_W - 1;
  localparam int POS_W    = $clog2(LAST_POS + 1);
  localparam int GCNT_W   = GUARD_W + 1;

  logic              busy_q;
  logic [SH_W-1:0]   sh_q;
  logic [GCNT_W-1:0] gleft_q;
  logic [POS_W-1:0]  pos_q;
  logic              accept;

  assign accept = en && !busy_q && in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sh_q    <= '1;
      gleft_q <= '0;
      pos_q   <= '0;
    end else if (!en) begin
      busy_q <= 1'b0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      sh_q    <= {1'b1, sc_encode(in_data, inv), 1'b0};
      gleft_q <= {guard, 1'b0};
      pos_q   <= '0;
    end else if (busy_q && half_tick) begin
      if (gleft_q != '0) begin
        gleft_q <= gleft_q - 1'b1;
      end else if (pos_q == POS_W'(LAST_POS)) begin
        busy_q <= 1'b0;
      end else begin
        pos_q <= pos_q + 1'b1;
        if (pos_q[0]) sh_q <= {1'b1, sh_q[SH_W-1:1]};
      end
    end
  end

  assign in_ready  = en && !busy_q;
  assign busy      = busy_q;
  assign drive_low = busy_q && (gleft_q == '0) && !sh_q[0];
endmodule

// File: rtl/sc_rx.sv
module sc_rx
  import sc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 half_tick,
  input  logic                 line,
  output logic                 done,
  output logic [SC_DATA_W-1:0] raw,
  output logic                 praw
);
  localparam int LAST_CNT = 2 * (SC_DATA_W + 1);
  localparam int CNT_W    = $clog2(LAST_CNT + 1);

  rx_st_e               st_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [SC_DATA_W-1:0] raw_q;
  logic                 praw_q;
  logic                 done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      raw_q  <= '0;
      praw_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en) begin
        st_q <= RX_IDLE;
      end else begin
        case (st_q)
          RX_IDLE: if (!line) begin
            st_q  <= RX_RUN;
            cnt_q <= '0;
          end
          RX_RUN: if (half_tick) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == '0) begin
              if (line) st_q <= RX_IDLE;        // glitch, not a start bit
            end else if (cnt_q == CNT_W'(LAST_CNT)) begin
              praw_q <= line;
              done_q <= 1'b1;
              st_q   <= RX_STOP;
            end else if (!cnt_q[0]) begin
              raw_q <= {line, raw_q[SC_DATA_W-1:1]};
            end
          end
          RX_STOP: if (line) st_q <= RX_IDLE;
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign done = done_q;
  assign raw  = raw_q;
  assign praw = praw_q;
endmodule

// File: rtl/sc_conv.sv
module sc_conv
  import sc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 auto_n,
  input  logic                 conv_sw,
  input  logic                 session,
  input  logic                 done,
  input  logic [SC_DATA_W-1:0] raw,
  output logic                 conv,
  output logic                 conv_dec,
  output logic                 err
);
  logic auto_q, armed_q, err_q;
  logic is_dir, is_inv, hunting, detect;

  assign is_dir  = (raw == TS_DIRECT_RAW);
  assign is_inv  = (raw == TS_INVERSE_RAW);
  assign hunting = !auto_n && session && armed_q;
  assign detect  = hunting && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_q  <= 1'b0;
      armed_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      if (!session) begin
        armed_q <= 1'b1;
        err_q   <= 1'b0;
      end else if (done) begin
        armed_q <= 1'b0;
      end
      if (detect) begin
        if (is_dir)      auto_q <= 1'b0;
        else if (is_inv) auto_q <= 1'b1;
        else             err_q  <= 1'b1;
      end
    end
  end

  assign conv     = auto_n ? conv_sw : auto_q;
  assign conv_dec = hunting ? (is_dir ? 1'b0 : (is_inv ? 1'b1 : auto_q)) : conv;
  assign err      = err_q;
endmodule

// File: rtl/sc_char_engine.sv
module sc_char_engine
  import sc_pkg::*;
#(
  parameter int   GUARD_W = 8,
  parameter logic HAS_CLK = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               half_tick,
  input  logic               sync_mode,
  input  logic               auto_conv_n,
  input  logic               conv_sw,
  input  logic               start_session,
  input  logic [GUARD_W-1:0] guard_etu,
  input  logic               sync_clk_ctl,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [7:0]         tx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [7:0]         rx_data,
  output logic               rx_parity_err,
  output logic               conv_state,
  output logic               conv_err,
  input  logic               io_in,
  output logic               io_drive_low,
  output logic               card_clk
);
  logic                 io_q, sync_bit_q;
  logic                 tx_rdy, tx_busy, tx_low;
  logic                 rx_done, rx_praw;
  logic [SC_DATA_W-1:0] rx_raw;
  logic                 conv, conv_dec;
  logic [SC_DATA_W:0]   dec;
  logic [SC_DATA_W-1:0] rx_data_q;
  logic                 rx_perr_q, rx_valid_q;

  sc_tx #(.GUARD_W(GUARD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(!sync_mode), .half_tick(half_tick),
    .inv(conv), .guard(guard_etu), .in_valid(tx_valid), .in_data(tx_data),
    .in_ready(tx_rdy), .busy(tx_busy), .drive_low(tx_low)
  );

  sc_rx u_rx (
    .clk(clk), .rst_n(rst_n), .en(!sync_mode && !tx_busy), .half_tick(half_tick),
    .line(io_q), .done(rx_done), .raw(rx_raw), .praw(rx_praw)
  );

  sc_conv u_conv (
    .clk(clk), .rst_n(rst_n), .auto_n(auto_conv_n), .conv_sw(conv_sw),
    .session(start_session), .done(rx_done), .raw(rx_raw),
    .conv(conv), .conv_dec(conv_dec), .err(conv_err)
  );

  assign dec = sc_decode(rx_raw, rx_praw, conv_dec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_q       <= 1'b1;
      sync_bit_q <= 1'b1;
      rx_data_q  <= '0;
      rx_perr_q  <= 1'b0;
      rx_valid_q <= 1'b0;
    end else begin
      io_q <= io_in;
      if (sync_mode && tx_valid) sync_bit_q <= tx_data[0];
      if (rx_done) begin
        rx_data_q  <= dec[SC_DATA_W-1:0];
        rx_perr_q  <= dec[SC_DATA_W];
        rx_valid_q <= 1'b1;
      end else if (rx_valid_q && rx_ready) begin
        rx_valid_q <= 1'b0;
      end
    end
  end

  generate
    if (HAS_CLK) begin : g_clk
      assign card_clk = sync_mode && sync_clk_ctl;
    end else begin : g_noclk
      assign card_clk = 1'b0;
    end
  endgenerate

  assign tx_ready      = sync_mode ? 1'b1 : tx_rdy;
  assign io_drive_low  = sync_mode ? !sync_bit_q : tx_low;
  assign rx_valid      = !sync_mode && rx_valid_q;
  assign rx_data       = sync_mode ? {7'b0, io_q} : rx_data_q;
  assign rx_parity_err = !sync_mode && rx_perr_q;
  assign conv_state    = conv;
endmodule

// File: rtl/sc_char_engine_chk.sv
module sc_char_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_mode,
  input logic       auto_conv_n,
  input logic       start_session,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       conv_state,
  input logic       conv_err,
  input logic       io_drive_low,
  input logic       card_clk
);
  assert_tx_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && tx_valid && tx_ready) |=> (sync_mode || !tx_ready));

  assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && rx_valid && !rx_ready) |=> (sync_mode || rx_valid));

  assert_conv_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_session && $past(!start_session) && !auto_conv_n && $past(!auto_conv_n))
      |-> $stable(conv_state));

  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_session |=> !conv_err);

  assert_sync_io_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && tx_valid && tx_ready) |=> (!sync_mode || (io_drive_low == !$past(tx_data[0]))));

  assert_clk_async_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> !card_clk);
endmodule

bind sc_char_engine sc_char_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .auto_conv_n(auto_conv_n),
  .start_session(start_session), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .conv_state(conv_state), .conv_err(conv_err), .io_drive_low(io_drive_low),
  .card_clk(card_clk)
);

// File: tb/sim_sc_char_engine.sv
`timescale 1ns/1ps
module sim_sc_char_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_tick = 1'b0;
  logic       sync_mode = 1'b0, auto_conv_n = 1'b1, conv_sw = 1'b0, start_session = 1'b0;
  logic [7:0] guard_etu = 8'd0;
  logic       sync_clk_ctl = 1'b0;
  logic       tx_valid = 1'b0, rx_ready = 1'b0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_ready, rx_valid, rx_parity_err, conv_state, conv_err, io_drive_low, card_clk;
  logic [7:0] rx_data;
  logic       card_low = 1'b0;
  logic       io_in;
  int         checks = 0, errors = 0;

  assign io_in = !(io_drive_low || card_low);

  always #10 clk = ~clk;   // 50 MHz

  sc_char_engine u0 (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .sync_mode(sync_mode),
    .auto_conv_n(auto_conv_n), .conv_sw(conv_sw), .start_session(start_session),
    .guard_etu(guard_etu), .sync_clk_ctl(sync_clk_ctl), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_parity_err(rx_parity_err), .conv_state(conv_state),
    .conv_err(conv_err), .io_in(io_in), .io_drive_low(io_drive_low), .card_clk(card_clk)
  );

  initial begin
    forever begin
      repeat (7) @(negedge clk);
      half_tick = 1'b1;
      @(negedge clk);
      half_tick = 1'b0;
    end
  end

  function automatic logic [8:0] enc(input logic [7:0] d, input logic inv);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = inv ? ~d[7-i] : d[i];
    return {inv ? ~(^d) : (^d), r};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ht();
    do @(posedge clk); while (!half_tick);
  endtask

  task automatic wait_ht_n(input int n);
    for (int k = 0; k < n; k++) wait_ht();
    @(negedge clk);
  endtask

  task automatic tx_frame(input string tag, input logic [7:0] d, input logic inv,
                          input logic [7:0] g);
    logic [8:0] e;
    int n;
    e = enc(d, inv);
    @(negedge clk);
    conv_sw = inv; guard_etu = g; tx_data = d; tx_valid = 1'b1;
    chk({tag, " ready before send"}, tx_ready, 1);
    @(negedge clk);
    tx_valid = 1'b0;
    n = 0;
    while (!io_drive_low && n < 2000) begin
      wait_ht(); @(negedge clk); n++;
    end
    chk({tag, " R4 guard half ticks"}, n, 2 * g);
    wait_ht_n(1);
    chk({tag, " start bit"}, io_in, 0);
    for (int i = 0; i < 9; i++) begin
      wait_ht_n(2);
      chk($sformatf("%s bit %0d", tag, i), io_in, e[i]);
    end
    chk({tag, " R2 busy"}, tx_ready, 0);
    wait_ht_n(2);
    chk({tag, " R2 stop bit"}, io_in, 1);
    wait_ht_n(1);
    chk({tag, " R2 ready after stop"}, tx_ready, 1);
  endtask

  task automatic card_char(input logic [8:0] lb);
    wait_ht_n(1);
    card_low = 1'b1;
    wait_ht_n(2);
    for (int i = 0; i < 9; i++) begin
      card_low = !lb[i];
      wait_ht_n(2);
    end
    card_low = 1'b0;
    wait_ht_n(2);
  endtask

  task automatic rx_take();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic rx_expect(input string tag, input logic [7:0] d, input logic perr);
    chk({tag, " valid"}, rx_valid, 1);
    chk({tag, " data"}, rx_data, d);
    chk({tag, " parity flag"}, rx_parity_err, perr);
    rx_take();
  endtask

  task automatic t_reset();
    chk("R1 line released", io_drive_low, 0);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 conv_state", conv_state, 0);
    chk("R1 conv_err", conv_err, 0);
    chk("R1 card_clk", card_clk, 0);
  endtask

  task automatic t_tx();
    tx_frame("R2 direct A5", 8'hA5, 1'b0, 8'd0);
    tx_frame("R2 direct 3C", 8'h3C, 1'b0, 8'd0);
    tx_frame("R3 inverse 5A", 8'h5A, 1'b1, 8'd0);
    tx_frame("R3 inverse 81", 8'h81, 1'b1, 8'd0);
    tx_frame("R4 guard 3", 8'h69, 1'b0, 8'd3);
    tx_frame("R4 guard 1", 8'hF0, 1'b1, 8'd1);
    conv_sw = 1'b0; guard_etu = 8'd0;
  endtask

  task automatic t_rx();
    logic [8:0] lb;
    conv_sw = 1'b0;
    card_char(enc(8'h96, 1'b0));
    chk("R5 valid", rx_valid, 1);
    repeat (5) @(negedge clk);
    chk("R5 valid held", rx_valid, 1);
    rx_expect("R5 direct 96", 8'h96, 1'b0);
    chk("R5 valid cleared", rx_valid, 0);
    lb = enc(8'h4B, 1'b0);
    lb[8] = ~lb[8];
    card_char(lb);
    rx_expect("R5 bad parity", 8'h4B, 1'b1);
    conv_sw = 1'b1;
    card_char(enc(8'hC4, 1'b1));
    rx_expect("R6 inverse C4", 8'hC4, 1'b0);
    card_char(enc(8'h07, 1'b1));
    rx_expect("R6 inverse 07", 8'h07, 1'b0);
    conv_sw = 1'b0;
  endtask

  task automatic t_auto();
    @(negedge clk);
    auto_conv_n = 1'b0; start_session = 1'b0;
    @(negedge clk);
    start_session = 1'b1;
    card_char(enc(8'h3F, 1'b1));
    chk("R7 inverse detected", conv_state, 1);
    rx_expect("R7 TS inverse", 8'h3F, 1'b0);
    card_char(enc(8'h12, 1'b1));
    chk("R7 later char keeps conv", conv_state, 1);
    rx_expect("R7 second char", 8'h12, 1'b0);
    card_char(enc(8'h3B, 1'b0));
    chk("R7 3B late ignored", conv_state, 1);
    rx_take();
    start_session = 1'b0;
    repeat (2) @(negedge clk);
    start_session = 1'b1;
    card_char(enc(8'h3B, 1'b0));
    chk("R7 direct detected", conv_state, 0);
    rx_expect("R7 TS direct", 8'h3B, 1'b0);
    start_session = 1'b0;
    repeat (2) @(negedge clk);
    start_session = 1'b1;
    card_char(enc(8'h55, 1'b0));
    chk("R8 unknown keeps conv", conv_state, 0);
    chk("R8 error raised", conv_err, 1);
    rx_expect("R8 unknown decoded", 8'h55, 1'b0);
    start_session = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 error cleared", conv_err, 0);
  endtask

  task automatic t_manual();
    auto_conv_n = 1'b1; conv_sw = 1'b0; start_session = 1'b1;
    @(negedge clk);
    card_char(enc(8'h3F, 1'b1));
    chk("R9 conv not detected", conv_state, 0);
    rx_expect("R9 decoded direct", 8'h03, 1'b1);
    conv_sw = 1'b1;
    @(negedge clk);
    chk("R9 follows conv_sw", conv_state, 1);
    conv_sw = 1'b0; start_session = 1'b0;
    @(negedge clk);
    chk("R9 follows conv_sw low", conv_state, 0);
  endtask

  task automatic t_sync();
    @(negedge clk);
    sync_mode = 1'b1; sync_clk_ctl = 1'b0;
    @(negedge clk);
    chk("R10 tx_ready", tx_ready, 1);
    chk("R11 clk low", card_clk, 0);
    tx_data = 8'hFE; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R10 bit0=0 drives low", io_drive_low, 1);
    tx_data = 8'h01; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk("R10 bit0=1 releases", io_drive_low, 0);
    card_low = 1'b1;
    @(negedge clk);
    chk("R10 rx bit low", rx_data, 8'h00);
    card_low = 1'b0;
    @(negedge clk);
    chk("R10 rx bit high", rx_data, 8'h01);
    chk("R10 rx_valid low", rx_valid, 0);
    sync_clk_ctl = 1'b1;
    @(negedge clk);
    chk("R11 clk follows control", card_clk, 1);
    sync_mode = 1'b0;
    @(negedge clk);
    chk("R11 clk off in async", card_clk, 0);
    sync_clk_ctl = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx();
    t_rx();
    t_auto();
    t_manual();
    t_sync();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule